// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Edge Address Generator

This block produces the check-side edge addresses that one bit-processing element of a partially parallel quasi-cyclic LDPC decoder needs. The parity-check matrix is an array of `NBR` by `NBC` circulant permutation blocks, each `P` by `P` with `P` prime. The block in block row `i` and block column `j` is the cyclic shift by exponent `e(i,j)`. Bit node `k` of block column `j` therefore meets block row `i` at check row `(k + e(i,j)) mod P`. All check-node edge values live in one memory, laid out block row by block row and then block column by block column, so the edge address is `i*P*NBC + j*P + ((k + e(i,j)) mod P)`.

The exponents are written into a small table at configuration time. A start pulse names the bit-processing element, which is also its block column. The generator then walks that element's bit nodes one after another. For each node it visits the block rows in order and emits one address per cycle with a valid strobe and a final-edge flag. The modulo is never divided out: each block row keeps a running offset that is seeded from the table and stepped by one with a compare-and-wrap. The memories that use these addresses are outside the block.

Top module: `qc_edge_addr_gen`

## Requirements
- R1: After reset `busy` and `edge_valid` are 0 and every exponent in the table is 0, so a run before any table write produces check row `k` for node `k`.
- R2: Every valid address equals `i*P*NBC + j*P + ((k + e(i,j)) mod P)`, where `i` is `edge_cpe`, `k` is `edge_node` and `j` is the block column that was started.
- R3: When a start is accepted, the first valid output appears in the next cycle with node 0 and block row 0. Outputs then follow on consecutive cycles, node-major: for each node `k` from 0 to `P-1`, the block rows run 0 to `NBR-1`. That makes `P*NBR` outputs in all.
- R4: `edge_last` is 1 only on the output for node `P-1` in block row `NBR-1`, and `edge_valid` is 0 in the cycle after it unless a new start was accepted there.
- R5: A start while `busy` is 1 is ignored and the run in progress continues unchanged.
- R6: A start whose `bpe_id` is `NBC` or more is ignored: no output is produced and `busy` stays 0.
- R7: A written exponent value `v` with `P <= v < 2^PW` is stored as `v - P`, and values below `P` are stored as they are.
- R8: A table write with `cfg_row >= NBR` or `cfg_col >= NBC` changes no entry.
- R9: The exponents of a run are captured when its start is accepted. Table writes during the run do not change its addresses, and they take effect from the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Exponent table write strobe |
| cfg_row | input | RW | Block row of the written exponent |
| cfg_col | input | CW | Block column of the written exponent |
| cfg_exp | input | PW | Exponent value to write |
| start | input | 1 | Request a walk over one processing element |
| bpe_id | input | CW | Bit-processing element (block column) to walk |
| busy | output | 1 | A walk is in progress |
| edge_valid | output | 1 | `edge_addr` carries an address this cycle |
| edge_addr | output | AW | Check-node edge memory address |
| edge_node | output | PW | Bit node index within the element |
| edge_cpe | output | RW | Block row (check-PE) of this edge |
| edge_last | output | 1 | Final edge of the walk |

## Verification
On every cycle the assertions check the following. Stored exponents and running offsets stay below `P`. Every address lies inside the edge memory. The final-edge flag only comes with a valid strobe, and the strobe drops after it. An accepted start yields node 0, row 0 on the next cycle. Row and node indices advance in node-major order. The exact address values depend on the exponent table and on when writes happen relative to a start, so only the bench can show them. It sweeps every block column against an arithmetic model, with exponent values that need reduction, out-of-range writes and starts, and starts and table writes injected mid-run.

// File: rtl/qc_addr_pkg.sv
package qc_addr_pkg;

  // one compare-and-subtract: valid for inputs below 2*p
  function automatic int unsigned fold_once(input int unsigned v, input int unsigned p);
    return (v >= p) ? v - p : v;
  endfunction

  // step a residue by one modulo p
  function automatic int unsigned step_wrap(input int unsigned v, input int unsigned p);
    return (v + 1 >= p) ? 0 : v + 1;
  endfunction

  // flat edge location: block row major, then block column, then check row
  function automatic int unsigned edge_loc(input int unsigned row, input int unsigned col,
                                           input int unsigned ofs, input int unsigned p,
                                           input int unsigned ncols);
    return row * p * ncols + col * p + ofs;
  endfunction

endpackage

// File: rtl/qc_exp_table.sv
module qc_exp_table #(
  parameter int unsigned P   = 7,
  parameter int unsigned NBR = 3,
  parameter int unsigned NBC = 5,
  localparam int unsigned PW = $clog2(P),
  localparam int unsigned RW = (NBR > 1) ? $clog2(NBR) : 1,
  localparam int unsigned CW = (NBC > 1) ? $clog2(NBC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RW-1:0]       wr_row,
  input  logic [CW-1:0]       wr_col,
  input  logic [PW-1:0]       wr_val,
  input  logic [CW-1:0]       rd_col,
  output logic [NBR*PW-1:0]   rd_exps
);
  localparam logic [RW:0] NBR_X = (RW+1)'(NBR);
  localparam logic [CW:0] NBC_X = (CW+1)'(NBC);

  logic [NBR-1:0][NBC-1:0][PW-1:0] tbl_q;
  logic                            wr_hit;
  logic [PW-1:0]                   wr_folded;

  assign wr_hit    = wr_en && ({1'b0, wr_row} < NBR_X) && ({1'b0, wr_col} < NBC_X);
  assign wr_folded = PW'(qc_addr_pkg::fold_once(32'(wr_val), P));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (wr_hit) begin
      tbl_q[wr_row][wr_col] <= wr_folded;
    end
  end

  for (genvar r = 0; r < NBR; r++) begin : g_rd
    assign rd_exps[r*PW +: PW] = tbl_q[r][rd_col];
    for (genvar c = 0; c < NBC; c++) begin : g_chk
      // R7: every stored exponent is already reduced below P
      assert_exp_reduced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tbl_q[r][c]) < P);
    end
  end

endmodule

// File: rtl/qc_row_offsets.sv
module qc_row_offsets #(
  parameter int unsigned P   = 7,
  parameter int unsigned NBR = 3,
  localparam int unsigned PW = $clog2(P),
  localparam int unsigned RW = (NBR > 1) ? $clog2(NBR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              step,
  input  logic [NBR*PW-1:0] seed_exps,
  input  logic [RW-1:0]     sel_row,
  output logic [PW-1:0]     ofs
);
  logic [NBR-1:0][PW-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else begin
      for (int r = 0; r < NBR; r++) begin
        if (seed) begin
          ofs_q[r] <= seed_exps[r*PW +: PW];
        end else if (step) begin
          ofs_q[r] <= PW'(qc_addr_pkg::step_wrap(32'(ofs_q[r]), P));
        end
      end
    end
  end

  assign ofs = ofs_q[sel_row];

  for (genvar r = 0; r < NBR; r++) begin : g_chk
    // R2: running residue of each block row never reaches P
    assert_ofs_below_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ofs_q[r]) < P);
  end

endmodule

// File: rtl/qc_seq_ctrl.sv
module qc_seq_ctrl #(
  parameter int unsigned P   = 7,
  parameter int unsigned NBR = 3,
  parameter int unsigned NBC = 5,
  localparam int unsigned PW = $clog2(P),
  localparam int unsigned RW = (NBR > 1) ? $clog2(NBR) : 1,
  localparam int unsigned CW = (NBC > 1) ? $clog2(NBC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] bpe_id,
  output logic          busy,
  output logic [PW-1:0] node,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          take,
  output logic          node_done,
  output logic          last
);
  localparam logic [CW:0]   NBC_X    = (CW+1)'(NBC);
  localparam logic [RW-1:0] ROW_LAST = RW'(NBR - 1);
  localparam logic [PW-1:0] NODE_LAST = PW'(P - 1);

  logic busy_q;
  logic [PW-1:0] node_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  assign take      = start && !busy_q && ({1'b0, bpe_id} < NBC_X);
  assign node_done = busy_q && (row_q == ROW_LAST);
  assign last      = node_done && (node_q == NODE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      node_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      node_q <= '0;
      row_q  <= '0;
      col_q  <= bpe_id;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        row_q  <= '0;
      end else if (node_done) begin
        row_q  <= '0;
        node_q <= node_q + 1'b1;
      end else begin
        row_q  <= row_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign node = node_q;
  assign row  = row_q;
  assign col  = col_q;

  // R5: a start during a run leaves the block column of the run alone
  assert_col_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (col_q == $past(col_q)));

endmodule

// File: rtl/qc_edge_addr_gen.sv
module qc_edge_addr_gen #(
  parameter int unsigned P   = 7,
  parameter int unsigned NBR = 3,
  parameter int unsigned NBC = 5,
  localparam int unsigned PW = $clog2(P),
  localparam int unsigned RW = (NBR > 1) ? $clog2(NBR) : 1,
  localparam int unsigned CW = (NBC > 1) ? $clog2(NBC) : 1,
  localparam int unsigned NEDGE = P * NBR * NBC,
  localparam int unsigned AW = $clog2(NEDGE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_row,
  input  logic [CW-1:0] cfg_col,
  input  logic [PW-1:0] cfg_exp,
  input  logic          start,
  input  logic [CW-1:0] bpe_id,
  output logic          busy,
  output logic          edge_valid,
  output logic [AW-1:0] edge_addr,
  output logic [PW-1:0] edge_node,
  output logic [RW-1:0] edge_cpe,
  output logic          edge_last
);
  localparam logic [CW:0] NBC_X = (CW+1)'(NBC);

  logic [NBR*PW-1:0] col_exps;
  logic [PW-1:0]     cur_ofs;
  logic [PW-1:0]     node;
  logic [RW-1:0]     row;
  logic [CW-1:0]     col;
  logic              take;
  logic              node_done;
  logic              last;
  logic              run;

  qc_seq_ctrl #(.P(P), .NBR(NBR), .NBC(NBC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bpe_id(bpe_id),
    .busy(run), .node(node), .row(row), .col(col),
    .take(take), .node_done(node_done), .last(last)
  );

  qc_exp_table #(.P(P), .NBR(NBR), .NBC(NBC)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_row(cfg_row),
    .wr_col(cfg_col), .wr_val(cfg_exp), .rd_col(bpe_id), .rd_exps(col_exps)
  );

  qc_row_offsets #(.P(P), .NBR(NBR)) u_ofs (
    .clk(clk), .rst_n(rst_n), .seed(take), .step(node_done && !last),
    .seed_exps(col_exps), .sel_row(row), .ofs(cur_ofs)
  );

  assign busy       = run;
  assign edge_valid = run;
  assign edge_node  = node;
  assign edge_cpe   = row;
  assign edge_last  = last;
  assign edge_addr  = AW'(qc_addr_pkg::edge_loc(32'(row), 32'(col), 32'(cur_ofs), P, NBC));

  // events seen at the ports, restated for the checks below
  logic start_seen;
  assign start_seen = start && !busy && ({1'b0, bpe_id} < NBC_X);

  // R4: final flag only with a valid address
  assert_last_has_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_last |-> edge_valid);
  // R4: the walk ends after the final edge
  assert_valid_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_last && !start) |=> !edge_valid);
  // R2: the address stays inside the edge memory
  assert_addr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_valid |-> (32'(edge_addr) < NEDGE));
  // R3: an accepted start opens with node 0, block row 0
  assert_first_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (edge_valid && edge_node == '0 && edge_cpe == '0));
  // R3: rows advance within a node
  assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_valid && 32'(edge_cpe) != NBR - 1) |=>
      (edge_valid && edge_node == $past(edge_node) && edge_cpe == $past(edge_cpe) + 1'b1));
  // R3: nodes advance after the last block row
  assert_node_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_valid && !edge_last && 32'(edge_cpe) == NBR - 1) |=>
      (edge_valid && edge_cpe == '0 && edge_node == $past(edge_node) + 1'b1));

endmodule

// File: tb/tb_qc_edge_addr_gen.sv
`timescale 1ns/1ps
module tb_qc_edge_addr_gen;
  localparam int P = 7;
  localparam int NBR = 3;
  localparam int NBC = 5;
  localparam int PW = $clog2(P);
  localparam int RW = $clog2(NBR);
  localparam int CW = $clog2(NBC);
  localparam int AW = $clog2(P * NBR * NBC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [RW-1:0] cfg_row = '0;
  logic [CW-1:0] cfg_col = '0;
  logic [PW-1:0] cfg_exp = '0;
  logic start = 1'b0;
  logic [CW-1:0] bpe_id = '0;
  logic busy, edge_valid, edge_last;
  logic [AW-1:0] edge_addr;
  logic [PW-1:0] edge_node;
  logic [RW-1:0] edge_cpe;

  int checks = 0;
  int fails = 0;
  int model [NBR][NBC];

  always #4 clk = ~clk;

  qc_edge_addr_gen #(.P(P), .NBR(NBR), .NBC(NBC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_col(cfg_col),
    .cfg_exp(cfg_exp), .start(start), .bpe_id(bpe_id), .busy(busy),
    .edge_valid(edge_valid), .edge_addr(edge_addr), .edge_node(edge_node),
    .edge_cpe(edge_cpe), .edge_last(edge_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive cfg signals at the current negedge; model follows the requirement
  task automatic put_cfg(input int r, input int c, input int v);
    cfg_we = 1'b1; cfg_row = RW'(r); cfg_col = CW'(c); cfg_exp = PW'(v);
    if (r < NBR && c < NBC) model[r][c] = v % P;
  endtask

  task automatic write_exp(input int r, input int c, input int v);
    put_cfg(r, c, v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mode 0 plain, 1 start injected mid-run (R5), 2 table write mid-run (R9)
  task automatic run_col(input int j, input int mode);
    int snap [NBR];
    string areq;
    for (int i = 0; i < NBR; i++) snap[i] = model[i][j];
    areq = (mode == 1) ? "R5" : (mode == 2) ? "R9" : "R2";
    start = 1'b1; bpe_id = CW'(j);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < P * NBR; n++) begin
      int k = n / NBR;
      int i = n % NBR;
      int ea = i * P * NBC + j * P + (k + snap[i]) % P;
      chk(edge_valid == 1'b1, "R3", int'(edge_valid), 1);
      chk(int'(edge_node) * 16 + int'(edge_cpe) == k * 16 + i, "R3",
          int'(edge_node) * 16 + int'(edge_cpe), k * 16 + i);
      chk(int'(edge_addr) == ea, areq, int'(edge_addr), ea);
      chk(edge_last == (n == P * NBR - 1), "R4", int'(edge_last), int'(n == P * NBR - 1));
      if (n == 5 && mode == 1) begin start = 1'b1; bpe_id = CW'((j + 1) % NBC); end
      if (n == 5 && mode == 2) put_cfg(1, j, (model[1][j] + 3) % 8);
      @(negedge clk);
      if (n == 5) begin start = 1'b0; cfg_we = 1'b0; end
    end
    chk(edge_valid == 1'b0, "R4", int'(edge_valid), 0);
    chk(busy == 1'b0, "R4", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBR; i++) for (int j = 0; j < NBC; j++) model[i][j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset, cleared table
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(edge_valid == 1'b0, "R1", int'(edge_valid), 0);
    run_col(2, 0);

    // load table; raw values 0..7, the value 7 needs folding (R7)
    for (int i = 0; i < NBR; i++)
      for (int j = 0; j < NBC; j++)
        write_exp(i, j, (i * 3 + j * 2 + 1) % 8);
    for (int j = 0; j < NBC; j++) run_col(j, 0);

    // R7: explicit fold of value 7 into row 2, column 4
    write_exp(2, 4, 7);
    chk(model[2][4] == 0, "R7", model[2][4], 0);
    run_col(4, 0);

    // R8: out-of-range writes leave the table intact
    write_exp(3, 0, 5);
    write_exp(0, 5, 4);
    write_exp(0, 7, 2);
    run_col(0, 0);

    // R6: out-of-range element id produces nothing
    start = 1'b1; bpe_id = CW'(5);
    @(negedge clk);
    bpe_id = CW'(7);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 4; n++) begin
      chk(edge_valid == 1'b0 && busy == 1'b0, "R6", int'(edge_valid) + int'(busy), 0);
      @(negedge clk);
    end

    // R5: start during a run is ignored
    run_col(1, 1);
    // R9: write during a run keeps the run, applies to the next
    run_col(3, 2);
    run_col(3, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule